// File: doc/BRIEF.md
# Cartridge ROM Bank Controller

This block watches the write side of an 8-bit CPU bus with a 16-bit address and keeps the bank number for the switchable upper half of a 32 KiB cartridge ROM window. Software that stores into the ROM address range does not change ROM contents. The store reaches a bank-select register instead. How the data byte becomes a bank number depends on a mapper policy. The block decodes that policy from the cartridge header type byte, which is presented on a static input.

Three banking policies are supported: a narrow 5-bit field that keeps the two upper bank bits, a 7-bit field that turns 0 into 1, and a 7-bit field that allows bank 0. A fourth setting means "no mapper", and in it the bank never moves. A candidate bank is taken only when it lies inside the ROM. The ROM size is given as a count of 16 KiB banks. On the read side the block turns a 15-bit window offset into a physical ROM address. The lower 16 KiB always come from bank 0. The upper 16 KiB come from the selected bank.

Top module: `rom_bank_ctl`

## Requirements
- R1: After reset the selected bank (`bank_sel`) is 1.
- R2: Only a write whose address lies in 0x2000–0x3FFF can change the bank. Writes to 0x0000–0x1FFF, to 0x4000–0x7FFF or above 0x7FFF leave `bank_sel` unchanged.
- R3: For header codes 0x01, 0x02 and 0x03, data bits [4:0] replace bank bits [4:0], and a written value of 0 in that field becomes 1. Bank bits [6:5] keep their previous value, and data bits [7:5] are ignored.
- R4: For header codes 0x0F through 0x13, the new bank is data bits [6:0], a value of 0 becomes 1, and data bit 7 is ignored.
- R5: For header codes 0x19 through 0x1E, and for every header code not named in R3, R4 or R7, the new bank is data bits [6:0] and 0 is kept as bank 0.
- R6: A candidate bank is accepted only if it is below `rom_banks`, which means (bank+1)×16 KiB fits in the ROM. Otherwise the previous bank is kept.
- R7: For header codes 0x00, 0x08 and 0x09, every write is ignored and `bank_sel` stays 1.
- R8: `phys_addr` is combinational. When `rd_addr[14]` is 0 it equals {7'd0, rd_addr[13:0]}. When `rd_addr[14]` is 1 it equals {bank_sel, rd_addr[13:0]}.
- R9: An accepted write changes `bank_sel` at the rising clock edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per store |
| wr_addr | input | 16 | Bus write address |
| wr_data | input | 8 | Bus write data |
| cart_type | input | 8 | Cartridge header type code, static |
| rom_banks | input | 8 | ROM size as a count of 16 KiB banks, static |
| rd_addr | input | 15 | Read offset inside the 32 KiB ROM window |
| bank_sel | output | 7 | Currently selected upper bank |
| phys_addr | output | 21 | Physical ROM byte address for `rd_addr` |

## Verification
The bank register is the only stage of storage, so the effect of a write is due exactly one rising edge after the strobe is driven. The bench raises the strobe on a falling edge, checks `bank_sel` again just before the next rising edge to confirm that nothing has moved early, and reads the new value on the falling edge that follows. `phys_addr` carries no register. The bench therefore compares it a few nanoseconds after `rd_addr` changes, within the same cycle, and always away from the rising edge.

// File: rtl/rom_bank_pkg.sv
package rom_bank_pkg;

  typedef enum logic [2:0] {
    MAP_NONE = 3'd0,
    MAP_LOW5 = 3'd1,
    MAP_WIDE = 3'd2,
    MAP_FLAT = 3'd3
  } map_kind_e;

  // Header type byte to banking policy; unknown codes fall to the flat policy.
  function automatic map_kind_e kind_of(input logic [7:0] code);
    map_kind_e k;
    case (code)
      8'h00, 8'h08, 8'h09:               k = MAP_NONE;
      8'h01, 8'h02, 8'h03:               k = MAP_LOW5;
      8'h0F, 8'h10, 8'h11, 8'h12, 8'h13: k = MAP_WIDE;
      default:                           k = MAP_FLAT;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/rom_kind_decode.sv
module rom_kind_decode
  import rom_bank_pkg::*;
(
  input  logic [7:0] cart_type,
  output map_kind_e  kind
);

  always_comb kind = kind_of(cart_type);

  // R7: the three no-mapper codes must never select a banking policy
  always_comb begin
    if (cart_type == 8'h00 || cart_type == 8'h08 || cart_type == 8'h09)
      a_r7_none_codes: assert (kind == MAP_NONE);
  end

endmodule

// File: rtl/rom_bank_reg.sv
module rom_bank_reg
  import rom_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_W = 7,
  parameter int LOW_W  = 5,
  parameter int SIZE_W = 8,
  parameter logic [ADDR_W-1:0] SEL_LO = 16'h2000,
  parameter logic [ADDR_W-1:0] SEL_HI = 16'h3FFF,
  parameter logic [BANK_W-1:0] RST_BANK = 7'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  map_kind_e         kind,
  input  logic [SIZE_W-1:0] rom_banks,
  output logic [BANK_W-1:0] bank_q
);

  localparam int CMP_W = ((BANK_W > SIZE_W) ? BANK_W : SIZE_W) + 1;

  // Turn a written byte into a candidate bank under the given policy.
  function automatic logic [BANK_W-1:0] shape_bank(
    input map_kind_e         k,
    input logic [DATA_W-1:0] d,
    input logic [BANK_W-1:0] prev
  );
    logic [BANK_W-1:0] wide;
    logic [LOW_W-1:0]  low;
    logic [BANK_W-1:0] res;
    wide = d[BANK_W-1:0];
    low  = d[LOW_W-1:0];
    case (k)
      MAP_LOW5: begin
        res = prev;
        res[LOW_W-1:0] = (low == '0) ? LOW_W'(1) : low;
      end
      MAP_WIDE: res = (wide == '0) ? BANK_W'(1) : wide;
      default:  res = wide;
    endcase
    return res;
  endfunction

  // A bank fits when (bank + 1) banks do not exceed the ROM's bank count.
  function automatic logic bank_fits(
    input logic [BANK_W-1:0] b,
    input logic [SIZE_W-1:0] count
  );
    return CMP_W'(b) < CMP_W'(count);
  endfunction

  logic              sel_hit;
  logic              policy_on;
  logic [BANK_W-1:0] cand;
  logic              cand_ok;
  logic              bank_upd;

  assign sel_hit   = wr_en && (wr_addr >= SEL_LO) && (wr_addr <= SEL_HI);
  assign policy_on = (kind != MAP_NONE);
  assign cand      = shape_bank(kind, wr_data, bank_q);
  assign cand_ok   = bank_fits(cand, rom_banks);
  assign bank_upd  = sel_hit && policy_on && cand_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)        bank_q <= RST_BANK;
    else if (bank_upd) bank_q <= cand;
  end

  // R2: writes outside the select range leave the bank alone
  a_r2_outside_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_hit) |=> $stable(bank_q));

  // R6: any change of bank lands inside the ROM
  a_r6_bank_in_rom: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_q) |-> (CMP_W'(bank_q) < CMP_W'(rom_banks)));

  // R3 / R4: the zero-to-one policies never produce bank 0
  a_r4_no_zero_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bank_q) && $past(kind) != MAP_FLAT) |-> (bank_q != '0));

  // R7: with no mapper the bank never moves
  a_r7_none_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == MAP_NONE) |=> $stable(bank_q));

  // R3: the narrow policy keeps the upper bank bits
  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == MAP_LOW5) |=> (bank_q[BANK_W-1:LOW_W] == $past(bank_q[BANK_W-1:LOW_W])));

endmodule

// File: rtl/rom_addr_map.sv
module rom_addr_map #(
  parameter int BANK_W = 7,
  parameter int OFFS_W = 14
) (
  input  logic [OFFS_W:0]        rd_addr,
  input  logic [BANK_W-1:0]      bank,
  output logic [BANK_W+OFFS_W-1:0] phys_addr
);

  logic              upper_half;
  logic [BANK_W-1:0] eff_bank;

  assign upper_half = rd_addr[OFFS_W];
  assign eff_bank   = upper_half ? bank : '0;
  assign phys_addr  = {eff_bank, rd_addr[OFFS_W-1:0]};

  // R8: the lower half always reads bank 0 with the offset unchanged
  always_comb begin
    if (!rd_addr[OFFS_W])
      a_r8_low_half_bank0: assert (phys_addr[BANK_W+OFFS_W-1:OFFS_W] == '0);
  end

endmodule

// File: rtl/rom_bank_ctl.sv
module rom_bank_ctl
  import rom_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_W = 7,
  parameter int LOW_W  = 5,
  parameter int OFFS_W = 14,
  parameter int SIZE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [7:0]               cart_type,
  input  logic [SIZE_W-1:0]        rom_banks,
  input  logic [OFFS_W:0]          rd_addr,
  output logic [BANK_W-1:0]        bank_sel,
  output logic [BANK_W+OFFS_W-1:0] phys_addr
);

  map_kind_e kind;

  rom_kind_decode u_decode (
    .cart_type (cart_type),
    .kind      (kind)
  );

  rom_bank_reg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BANK_W (BANK_W),
    .LOW_W  (LOW_W),
    .SIZE_W (SIZE_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .kind      (kind),
    .rom_banks (rom_banks),
    .bank_q    (bank_sel)
  );

  rom_addr_map #(
    .BANK_W (BANK_W),
    .OFFS_W (OFFS_W)
  ) u_map (
    .rd_addr   (rd_addr),
    .bank      (bank_sel),
    .phys_addr (phys_addr)
  );

endmodule

// File: tb/rom_bank_ctl_tb.sv
module rom_bank_ctl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  cart_type = 8'h19;
  logic [7:0]  rom_banks = 8'd128;
  logic [14:0] rd_addr = '0;
  logic [6:0]  bank_sel;
  logic [20:0] phys_addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rom_bank_ctl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cart_type (cart_type),
    .rom_banks (rom_banks),
    .rd_addr   (rd_addr),
    .bank_sel  (bank_sel),
    .phys_addr (phys_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] code, input logic [7:0] banks);
    @(negedge clk);
    cart_type = code;
    rom_banks = banks;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive one store on a falling edge; the result is read on the next falling edge.
  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(8'h19, 8'd128);
    chk("R1 reset bank", int'(bank_sel), 1);
    rd_addr = 15'h4123;
    #1 chk("R8 upper half after reset", int'(phys_addr), (1 << 14) | 'h0123);
  endtask

  task automatic t_region;
    do_reset(8'h19, 8'd128);
    bus_wr(16'h1FFF, 8'h09);
    chk("R2 write below range", int'(bank_sel), 1);
    bus_wr(16'h4000, 8'h09);
    chk("R2 write above range", int'(bank_sel), 1);
    bus_wr(16'hA000, 8'h09);
    chk("R2 write outside ROM", int'(bank_sel), 1);
    // R9: nothing moves before the sampling edge
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'h3FFF; wr_data = 8'h09;
    @(posedge clk); #1;
    @(negedge clk); #3;
    wr_en = 1'b0;
    chk("R9 new bank after edge", int'(bank_sel), 9);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'h2000; wr_data = 8'h0C;
    #3 chk("R9 no early change", int'(bank_sel), 9);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2 R9 write at range start", int'(bank_sel), 12);
  endtask

  task automatic t_low5;
    do_reset(8'h01, 8'd128);
    bus_wr(16'h2000, 8'h05);
    chk("R3 low field", int'(bank_sel), 5);
    bus_wr(16'h2000, 8'h00);
    chk("R3 zero becomes one", int'(bank_sel), 1);
    bus_wr(16'h2000, 8'hE7);
    chk("R3 high data bits ignored", int'(bank_sel), 7);
    // keep upper bits set under the flat policy, then switch to code 0x02
    cart_type = 8'h19;
    bus_wr(16'h2000, 8'h45);
    chk("R5 flat set 0x45", int'(bank_sel), 'h45);
    cart_type = 8'h02;
    bus_wr(16'h2000, 8'h03);
    chk("R3 upper bits kept", int'(bank_sel), 'h43);
    cart_type = 8'h03;
    bus_wr(16'h2000, 8'h20);
    chk("R3 zero field keeps upper", int'(bank_sel), 'h41);
  endtask

  task automatic t_wide;
    do_reset(8'h11, 8'd128);
    bus_wr(16'h2000, 8'h00);
    chk("R4 zero becomes one", int'(bank_sel), 1);
    bus_wr(16'h2000, 8'h7F);
    chk("R4 full field", int'(bank_sel), 'h7F);
    bus_wr(16'h2000, 8'h85);
    chk("R4 bit7 ignored", int'(bank_sel), 5);
    bus_wr(16'h2000, 8'h80);
    chk("R4 only bit7 set is zero", int'(bank_sel), 1);
  endtask

  task automatic t_flat;
    do_reset(8'h1B, 8'd128);
    bus_wr(16'h2000, 8'h00);
    chk("R5 zero kept", int'(bank_sel), 0);
    do_reset(8'h42, 8'd128);
    bus_wr(16'h2000, 8'h33);
    chk("R5 unknown code 0x42", int'(bank_sel), 'h33);
    bus_wr(16'h2000, 8'h00);
    chk("R5 unknown code zero kept", int'(bank_sel), 0);
  endtask

  task automatic t_reject;
    do_reset(8'h19, 8'd8);
    bus_wr(16'h2000, 8'h07);
    chk("R6 last bank accepted", int'(bank_sel), 7);
    bus_wr(16'h2000, 8'h08);
    chk("R6 bank past end rejected", int'(bank_sel), 7);
    bus_wr(16'h2000, 8'h00);
    chk("R6 bank 0 accepted", int'(bank_sel), 0);
    cart_type = 8'h01;
    bus_wr(16'h2000, 8'h10);
    chk("R6 narrow policy rejects 16", int'(bank_sel), 0);
  endtask

  task automatic t_none;
    do_reset(8'h00, 8'd128);
    bus_wr(16'h2000, 8'h05);
    chk("R7 code 0x00 ignores write", int'(bank_sel), 1);
    cart_type = 8'h08;
    bus_wr(16'h2000, 8'h06);
    chk("R7 code 0x08 ignores write", int'(bank_sel), 1);
    cart_type = 8'h09;
    bus_wr(16'h3000, 8'h00);
    chk("R7 code 0x09 ignores write", int'(bank_sel), 1);
  endtask

  task automatic t_phys;
    do_reset(8'h19, 8'd128);
    bus_wr(16'h2000, 8'h2A);
    rd_addr = 15'h3ABC;
    #1 chk("R8 lower half bank 0", int'(phys_addr), 'h3ABC);
    rd_addr = 15'h7ABC;
    #1 chk("R8 upper half selected bank", int'(phys_addr), ('h2A << 14) | 'h3ABC);
    rd_addr = 15'h4000;
    #1 chk("R8 upper half first byte", int'(phys_addr), 'h2A << 14);
  endtask

  initial begin
    t_reset;
    t_region;
    t_low5;
    t_wide;
    t_flat;
    t_reject;
    t_none;
    t_phys;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule